// File: doc/BRIEF.md
# Whole-Pixel Memory Word Packer

This block sits on the write side of a frame store. It takes a stream of pixels (or single colour samples) under a valid/ready handshake and packs them into wide memory words. Only whole pixels are placed in a word. A pixel is never split across two words. A word therefore carries at most `floor(WORD_W / PIX_W)` pixels, and the bits above the last lane are zero padding. A word is released as soon as its last lane is filled.

An end-of-frame flag travels with the final pixel of a frame. It closes the word being built at once, even when the word is only partly filled. The pixel count goes out with every word, so a downstream memory writer knows how many lanes are valid. Some example ratios follow from the lane rule:

- 24-bit pixels in a 32-bit word: one pixel per word, a quarter of the bits wasted.
- 24-bit pixels in a 256-bit word: ten pixels per word, 6.25 % wasted.
- 10-bit samples in a 16-bit word: one sample per word, six padding bits.
- 8-bit samples in a 16-bit word: two samples, nothing wasted.

The output stage holds one finished word. It stalls the input whenever that word is still waiting on the consumer.

Top module: `pixel_word_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Within a word, the k-th pixel accepted (counting from 0) occupies bits `[k*PIX_W +: PIX_W]`, so the first pixel sits in the least significant lane.
- R3: A word is emitted once `LANES = floor(WORD_W/PIX_W)` pixels have been accepted into it, with `out_count` equal to `LANES`; `out_count` is always between 1 and `LANES` while `out_valid` is high.
- R4: Bits from `LANES*PIX_W` up to `WORD_W-1` are always 0 while `out_valid` is high.
- R5: A pixel accepted with `in_eof` = 1 closes its word immediately:
  - the word carries that pixel and the pixels before it in the frame's current word, with `out_count` equal to their number;
  - the unfilled lanes are 0;
  - the next pixel starts a new word at lane 0.
- R6: While `out_valid` = 1 and `out_ready` = 0:
  - `in_ready` is 0;
  - on the next cycle `out_valid` stays 1, and `out_word` and `out_count` are unchanged.
- R7: No pixel is lost or duplicated. Every frame of n pixels yields exactly `ceil(n/LANES)` words, with the pixels in arrival order.
- R8: `out_valid` is high in the cycle after the clock edge that accepts a word's closing pixel.
- R9: With `PIX_W` = 10 and `WORD_W` = 16, every word holds one sample in bits [9:0], bits [15:10] are 0, and `out_count` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Pixel present on `in_pixel` |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pixel | input | PIX_W | Pixel or colour sample |
| in_eof | input | 1 | This pixel is the last of its frame |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | WORD_W | Packed word, lane 0 in the low bits, zero padding on top |
| out_count | output | $clog2(LANES+1) | Number of pixels in `out_word` |

## Verification
Directed frames are used first:

- a full word followed by a three-pixel tail, which separates lane-full closure from end-of-frame closure and shows the lane order;
- a one-pixel frame, which exposes stale lane contents and slot-index reset errors.

Constrained random traffic then mixes input gaps, random end-of-frame positions and consumer readiness of 100 %, 50 % and 20 %. The stalled phases expose dropped, duplicated or overwritten words, and the free-flowing phase exposes errors in issue timing.

A second instance with 10-bit samples in 16-bit words confirms that the one-lane case pads correctly.

// File: rtl/pxpk_pkg.sv
// Shared helpers for the pixel word packer.
// Assumes pixel width never exceeds word width.
package pxpk_pkg;

    // Number of whole pixels that fit in one memory word.
    function automatic int lanes_per_word(input int word_w, input int pix_w);
        return word_w / pix_w;
    endfunction

    // Width needed to hold a value from 0 to n.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Width of a lane index for n lanes (at least one bit).
    function automatic int index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pxpk_slot_ctrl.sv
// Lane index tracker: counts accepted pixels within the current word and
// flags the accept that closes it (last lane filled or end of frame).
// Assumes accept is a single-cycle qualified handshake.
module pxpk_slot_ctrl #(
    parameter int LANES = 10,
    parameter int IDX_W = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             eof,
    output logic [IDX_W-1:0] slot_idx,
    output logic             close,
    output logic [CNT_W-1:0] fill_count
);

    logic last_lane;

    // Decide whether this accept finishes the word, and how full it is.
    always_comb begin
        last_lane  = (slot_idx == IDX_W'(LANES - 1));
        close      = accept && (last_lane || eof);
        fill_count = CNT_W'(slot_idx) + CNT_W'(1);
    end

    // Advance the lane index, returning to lane 0 when a word closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
        end else if (accept) begin
            slot_idx <= close ? '0 : slot_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/pxpk_lane_store.sv
// Lane storage: keeps the pixels of the word under construction and presents
// the word as it would look with the current pixel merged into its lane.
// Assumes the caller loads the merged word when close is high.
// Lanes are cleared on close so that partial words carry zero lanes.
module pxpk_lane_store #(
    parameter int PIX_W  = 24,
    parameter int WORD_W = 256,
    parameter int LANES  = 10,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              close,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [PIX_W-1:0]  pixel,
    output logic [WORD_W-1:0] merged
);

    localparam int USED_W = LANES * PIX_W;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            logic [PIX_W-1:0] lane_q;
            logic [PIX_W-1:0] lane_next;

            // Select the incoming pixel for the addressed lane.
            always_comb begin
                lane_next = (slot_idx == IDX_W'(gi)) ? pixel : lane_q;
            end

            // Hold the lane, clearing it when the word leaves.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (accept) begin
                    lane_q <= close ? '0 : lane_next;
                end
            end

            assign merged[gi*PIX_W +: PIX_W] = lane_next;
        end

        if (WORD_W > USED_W) begin : g_pad
            assign merged[WORD_W-1:USED_W] = '0;
        end
    endgenerate

endmodule

// File: rtl/pxpk_out_hold.sv
// Output holding register: one packed word with valid/ready. It reports
// itself free when empty or when the held word leaves this cycle.
// Assumes load is only raised while free is high.
module pxpk_out_hold #(
    parameter int WORD_W = 256,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [CNT_W-1:0]  out_count,
    output logic              free
);

    // Space is available when empty or draining this cycle.
    always_comb begin
        free = !out_valid || out_ready;
    end

    // Track whether a word is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Capture word and count when a word closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_count <= '0;
        end else if (load) begin
            out_word  <= word_in;
            out_count <= count_in;
        end
    end

endmodule

// File: rtl/pixel_word_packer.sv
// Whole-pixel word packer top. Pixels enter under valid/ready and are placed
// into lanes of a memory word, lane 0 lowest. A word leaves when its last lane
// fills or when a pixel marked end-of-frame arrives. Upper leftover bits are
// zero. Assumes PIX_W <= WORD_W.
module pixel_word_packer
    import pxpk_pkg::*;
#(
    parameter int  PIX_W  = 24,
    parameter int  WORD_W = 256,
    localparam int LANES  = lanes_per_word(WORD_W, PIX_W),
    localparam int CNT_W  = count_width(LANES),
    localparam int IDX_W  = index_width(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [CNT_W-1:0]  out_count
);

    logic              accept;
    logic              close;
    logic [IDX_W-1:0]  slot_idx;
    logic [CNT_W-1:0]  fill_count;
    logic [WORD_W-1:0] merged;
    logic              free;

    // Handshake: take a pixel only when the output stage can absorb a word.
    always_comb begin
        in_ready = free;
        accept   = in_valid && free;
    end

    pxpk_slot_ctrl #(
        .LANES (LANES),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .eof        (in_eof),
        .slot_idx   (slot_idx),
        .close      (close),
        .fill_count (fill_count)
    );

    pxpk_lane_store #(
        .PIX_W  (PIX_W),
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W)
    ) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .close    (close),
        .slot_idx (slot_idx),
        .pixel    (in_pixel),
        .merged   (merged)
    );

    pxpk_out_hold #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (close),
        .word_in   (merged),
        .count_in  (fill_count),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_count (out_count),
        .free      (free)
    );

endmodule

// File: rtl/pixel_word_packer_chk.sv
// Protocol and format checker for the pixel word packer, bound to every
// instance. Observes ports only.
module pixel_word_packer_chk
    import pxpk_pkg::*;
#(
    parameter int  PIX_W  = 24,
    parameter int  WORD_W = 256,
    localparam int LANES  = lanes_per_word(WORD_W, PIX_W),
    localparam int CNT_W  = count_width(LANES),
    localparam int USED_W = LANES * PIX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eof,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [CNT_W-1:0]  out_count
);

    // R6: a stalled word stays put
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_count));

    // R6: input blocked while a word is stuck
    a_r6_input_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R3: count stays in range
    a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != '0) && (int'(out_count) <= LANES));

    // R8 / R5: an end-of-frame pixel produces a word next cycle
    a_r8_eof_issues: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_eof |=> out_valid);

    generate
        if (WORD_W > USED_W) begin : g_pad_chk
            // R4: padding bits are zero
            a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> out_word[WORD_W-1:USED_W] == '0);
        end
    endgenerate

endmodule

bind pixel_word_packer pixel_word_packer_chk #(
    .PIX_W  (PIX_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_count (out_count)
);

// File: tb/pixel_word_packer_bench.sv
module pixel_word_packer_bench;

    localparam int PW = 24;
    localparam int WW = 256;
    localparam int LN = WW / PW;
    localparam int CW = $clog2(LN + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_pixel = '0;
    logic          in_eof = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [WW-1:0] out_word;
    logic [CW-1:0] out_count;

    // narrow instance: 10-bit samples in 16-bit words
    logic        n_valid = 1'b0;
    logic        n_ready;
    logic [9:0]  n_pixel = '0;
    logic        n_out_valid;
    logic [15:0] n_out_word;
    logic        n_out_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pixel_word_packer #(.PIX_W(PW), .WORD_W(WW)) u_pixel_word_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_eof(in_eof), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_count(out_count)
    );

    pixel_word_packer #(.PIX_W(10), .WORD_W(16)) u_pixel_word_packer_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_ready(n_ready),
        .in_pixel(n_pixel), .in_eof(1'b0), .out_valid(n_out_valid),
        .out_ready(1'b1), .out_word(n_out_word), .out_count(n_out_count)
    );

    // reference model state
    logic [WW-1:0] exp_w[$];
    int            exp_c[$];
    logic [WW-1:0] bld_word = '0;
    int            bld_cnt = 0;
    int            frame_pix = 0;
    int            exp_total = 0;
    int            got_words = 0;
    bit            pend_valid = 0;
    bit            pend_stall = 0;
    logic [WW-1:0] stall_word;
    logic [CW-1:0] stall_cnt;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample, let the edge happen, update model.
    task automatic step(input bit v, input logic [PW-1:0] p, input bit e,
                        input bit r, output bit acc);
        bit fire;
        logic [WW-1:0] w;
        logic [CW-1:0] c;
        @(negedge clk);
        in_valid  = v;
        in_pixel  = p;
        in_eof    = e;
        out_ready = r;
        #1;
        if (pend_valid) chk(out_valid, "R8 word issue timing", WW'(out_valid), WW'(1));
        if (pend_stall) begin
            chk(out_valid, "R6 valid held", WW'(out_valid), WW'(1));
            chk(out_word == stall_word && out_count == stall_cnt, "R6 word stable",
                out_word, stall_word);
        end
        if (out_valid && !r) chk(!in_ready, "R6 in_ready low on stall", WW'(in_ready), WW'(0));
        acc  = v && in_ready;
        fire = out_valid && r;
        w    = out_word;
        c    = out_count;
        pend_stall = out_valid && !r;
        stall_word = out_word;
        stall_cnt  = out_count;
        pend_valid = 0;
        @(posedge clk);
        if (fire) begin
            got_words++;
            if (exp_w.size() == 0) begin
                chk(0, "R7 unexpected word", w, '0);
            end else begin
                chk(w == exp_w[0], "R2/R4/R5 word contents", w, exp_w[0]);
                chk(int'(c) == exp_c[0], "R3/R5 pixel count", WW'(c), WW'(exp_c[0]));
                void'(exp_w.pop_front());
                void'(exp_c.pop_front());
            end
        end
        if (acc) begin
            bld_word[bld_cnt*PW +: PW] = p;
            bld_cnt++;
            frame_pix++;
            if (bld_cnt == LN || e) begin
                exp_w.push_back(bld_word);
                exp_c.push_back(bld_cnt);
                bld_word = '0;
                bld_cnt = 0;
                pend_valid = 1;
            end
            if (e) begin
                exp_total += ceil_div(frame_pix, LN);
                frame_pix = 0;
            end
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        bit acc;
        bit have;
        bit e;
        logic [PW-1:0] p;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid, "R1 out_valid after reset", WW'(out_valid), WW'(0));
        chk(in_ready, "R1 in_ready after reset", WW'(in_ready), WW'(1));

        // directed: one full word then a three-pixel tail (R2, R3, R5)
        for (int k = 0; k < LN + 3; k++) begin
            acc = 0;
            while (!acc) step(1, PW'(24'h100 + k), (k == LN + 2), 1, acc);
        end
        // directed: single-pixel frame (R5)
        acc = 0;
        while (!acc) step(1, 24'hABCDEF, 1, 1, acc);
        for (int k = 0; k < 3; k++) step(0, '0, 0, 1, acc);

        // random phases with decreasing consumer readiness (R6, R7)
        have = 0;
        p = '0;
        e = 0;
        for (int ph = 0; ph < 3; ph++) begin
            int rp;
            rp = (ph == 0) ? 100 : (ph == 1) ? 50 : 20;
            for (int n = 0; n < 2500; n++) begin
                if (!have && ($urandom % 100) < 80) begin
                    have = 1;
                    p = PW'($urandom);
                    e = (($urandom % 15) == 0);
                end
                step(have, p, e, (($urandom % 100) < rp), acc);
                if (acc) have = 0;
            end
        end
        // close the last frame, then drain
        acc = 0;
        while (!acc) step(1, PW'($urandom), 1, 1, acc);
        for (int k = 0; k < 10; k++) step(0, '0, 0, 1, acc);
        chk(exp_w.size() == 0, "R7 all words delivered", WW'(exp_w.size()), WW'(0));
        chk(got_words == exp_total, "R7 words per frame total", WW'(got_words), WW'(exp_total));

        // narrow instance: one 10-bit sample per 16-bit word (R9)
        begin
            logic [9:0] prev;
            prev = '0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (k > 0) begin
                    chk(n_out_valid && n_out_word == {6'b0, prev} && n_out_count == 1'b1,
                        "R9 narrow word", WW'(n_out_word), WW'({6'b0, prev}));
                end
                if (k < 5) begin
                    n_pixel = 10'($urandom) | 10'h200;
                    n_valid = 1'b1;
                    prev = n_pixel;
                end else begin
                    n_valid = 1'b0;
                end
            end
        end
        finish_run();
    end

endmodule